// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that retires one instruction on every rising clock edge. It runs nine operations: word load, word store, add, subtract, bitwise and, bitwise or, signed set-if-less, branch when two registers are equal, and an absolute jump. The program counter, a 32-entry register file, a word-organised instruction store and a separate word-organised data store all sit inside the block. Everything between the state elements is combinational: the instruction word is fetched, decoded, executed and written back within a single clock period.

Decoding takes two steps. A primary decoder turns the 6-bit operation code into a fixed set of datapath controls and a 2-bit ALU class. A second step narrows that class to an actual ALU function, using the 6-bit function field when the class says so. A testbench or boot agent fills both stores through a dedicated initialisation write port, normally while reset is held. Observation happens through a registered view of the PC and of each register-file write.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, every register becomes 0 and no register write is reported (`dbg_wr_en` = 0) in the following cycle.
- R2: Operation code 0 is register format. Its destination is bits 15:11 and its sources are bits 25:21 and 20:16. Function codes 32, 34, 36, 37 and 42 give add, subtract, and, or, and signed set-if-less (result 1 or 0). The PC then advances by 4.
- R3: Operation code 35 loads a word. It reads the data store at (source bits 25:21 + sign-extended bits 15:0), indexed by that byte address shifted right by 2, into the register named by bits 20:16.
- R4: Operation code 43 stores the register named by bits 20:16 to the data store at the same address form as R3. It writes no register, and a later load of that address returns the stored word.
- R5: Operation code 4 compares the registers named by bits 25:21 and 20:16. When they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2, which may point backwards. Otherwise the next PC is PC+4. It writes no register.
- R6: Operation code 2 sets the next PC to bits 31:28 of PC+4, then bits 25:0 of the instruction, then two zero bits. It writes no register.
- R7: Register 0 always reads as zero. An instruction that targets it changes no state and reports no write.
- R8: Any other operation code writes nothing and only advances the PC by 4.
- R9: One cycle after each edge that writes a register, `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show that write, and `dbg_pc` shows the PC of the next instruction.
- R10: The 16-bit immediate is sign-extended, so a negative offset in a load or store addresses below the base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| init_we | input | 1 | Initialisation write strobe |
| init_sel | input | 1 | Initialisation target: 0 instruction store, 1 data store |
| init_addr | input | max(IM_AW, DM_AW) | Word index of the initialisation write |
| init_data | input | 32 | Initialisation write word |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register was written at the last edge |
| dbg_wr_addr | output | 5 | Register number of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
Each instruction takes effect at the single rising edge after it is fetched. The new PC, and the registered record of any register write, are therefore visible one clock after the cycle that executed it, and the bench compares them at the falling edge that follows. A load or store result has no separate latency. A stored word is confirmed through a later load that surfaces it on the write record. The bench steps its own instruction-level model once per clock, in lockstep with the core, and checks every cycle of a program that sweeps all five ALU functions over every pair of eight boundary operands.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int IMM_W  = 16;
  localparam int JT_W   = 26;

  typedef enum logic [OPC_W-1:0] {
    OPC_RFMT = 6'd0,
    OPC_JMP  = 6'd2,
    OPC_BEQ  = 6'd4,
    OPC_LDW  = 6'd35,
    OPC_STW  = 6'd43
  } opcode_e;

  localparam logic [FN_W-1:0] FN_ADD = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB = 6'd34;
  localparam logic [FN_W-1:0] FN_AND = 6'd36;
  localparam logic [FN_W-1:0] FN_OR  = 6'd37;
  localparam logic [FN_W-1:0] FN_SLT = 6'd42;

  // ALU class handed from the primary decoder to the function refiner
  typedef enum logic [1:0] {
    ACLS_ADD  = 2'b00,
    ACLS_SUB  = 2'b01,
    ACLS_FUNC = 2'b10
  } alu_cls_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic     dst_is_rd;
    logic     b_is_imm;
    logic     wb_from_mem;
    logic     reg_we;
    logic     mem_we;
    logic     is_branch;
    logic     is_jump;
    alu_cls_e alu_cls;
  } ctrl_t;

endpackage

// File: rtl/oc_wordmem.sv
module oc_wordmem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Write on the clock edge, asynchronous read (distributed-RAM style)
  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
  parameter int NR = 32,
  parameter int DW = 32,
  localparam int AW = $clog2(NR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);

  logic [DW-1:0] rows [NR];

  for (genvar i = 0; i < NR; i++) begin : g_row
    if (i == 0) begin : g_zero
      // Entry zero is a constant: writes to it have nowhere to land
      assign rows[i] = '0;
    end else begin : g_flop
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (we && (waddr == AW'(i))) begin
          q <= wdata;
        end
      end
      assign rows[i] = q;
    end
  end

  assign rd1 = rows[ra1];
  assign rd2 = rows[ra2];

endmodule

// File: rtl/oc_decode.sv
module oc_decode
  import onecyc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctrl_t            ctrl,
  output alu_fn_e          alu_fn
);

  // Primary decode: one fixed control word per operation code
  always_comb begin
    ctrl         = '0;
    ctrl.alu_cls = ACLS_ADD;
    case (opcode)
      OPC_RFMT: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        ctrl.alu_cls   = ACLS_FUNC;
      end
      OPC_LDW: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
      end
      OPC_STW: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_cls   = ACLS_SUB;
      end
      OPC_JMP: begin
        ctrl.is_jump = 1'b1;
      end
      default: begin
        ctrl = '0;
      end
    endcase
  end

  // Second step: refine the class with the function field
  always_comb begin
    case (ctrl.alu_cls)
      ACLS_SUB: alu_fn = ALU_SUB;
      ACLS_FUNC: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/oc_alu.sv
module oc_alu
  import onecyc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_fn_e       fn,
  output logic [DW-1:0] y,
  output logic          zero
);

  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import onecyc_pkg::*;
#(
  parameter int IM_AW = 6,
  parameter int DM_AW = 6
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          init_we,
  input  logic                                          init_sel,
  input  logic [((IM_AW > DM_AW) ? IM_AW : DM_AW)-1:0]  init_addr,
  input  logic [XLEN-1:0]                               init_data,
  output logic [XLEN-1:0]                               dbg_pc,
  output logic                                          dbg_wr_en,
  output logic [RIDX_W-1:0]                             dbg_wr_addr,
  output logic [XLEN-1:0]                               dbg_wr_data
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_plus4;
  logic [XLEN-1:0]   br_target;
  logic [XLEN-1:0]   jmp_target;
  logic [XLEN-1:0]   pc_next;
  logic [XLEN-1:0]   cur_instr;

  logic [OPC_W-1:0]  f_opc;
  logic [FN_W-1:0]   f_fn;
  logic [RIDX_W-1:0] f_rs;
  logic [RIDX_W-1:0] f_rt;
  logic [RIDX_W-1:0] f_rd;
  logic [XLEN-1:0]   imm_sx;

  ctrl_t             ctrl;
  alu_fn_e           alu_fn;

  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic              alu_zero;

  logic [XLEN-1:0]   dm_rdata;
  logic              dm_init_we;
  logic              dm_core_we;
  logic              dm_we;
  logic [DM_AW-1:0]  dm_waddr;
  logic [XLEN-1:0]   dm_wdata;
  logic [DM_AW-1:0]  dm_idx;

  logic [RIDX_W-1:0] wb_dst;
  logic [XLEN-1:0]   wb_val;
  logic              rf_we;

  // ---------------- fetch ----------------
  oc_wordmem #(
    .AW(IM_AW),
    .DW(XLEN)
  ) u_imem (
    .clk   (clk),
    .we    (init_we & ~init_sel),
    .waddr (init_addr[IM_AW-1:0]),
    .wdata (init_data),
    .raddr (pc_q[IM_AW+1:2]),
    .rdata (cur_instr)
  );

  // ---------------- field split ----------------
  assign f_opc  = cur_instr[31:26];
  assign f_rs   = cur_instr[25:21];
  assign f_rt   = cur_instr[20:16];
  assign f_rd   = cur_instr[15:11];
  assign f_fn   = cur_instr[FN_W-1:0];
  assign imm_sx = {{(XLEN-IMM_W){cur_instr[IMM_W-1]}}, cur_instr[IMM_W-1:0]};

  oc_decode u_dec (
    .opcode (f_opc),
    .funct  (f_fn),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  // ---------------- operands ----------------
  oc_regfile #(
    .NR(NREG),
    .DW(XLEN)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (wb_dst),
    .wdata (wb_val),
    .ra1   (f_rs),
    .ra2   (f_rt),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  assign alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

  oc_alu #(
    .DW(XLEN)
  ) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // ---------------- data store ----------------
  assign dm_idx     = alu_y[DM_AW+1:2];
  assign dm_init_we = init_we & init_sel;
  assign dm_core_we = ctrl.mem_we & ~rst;
  assign dm_we      = dm_init_we | dm_core_we;
  assign dm_waddr   = dm_init_we ? init_addr[DM_AW-1:0] : dm_idx;
  assign dm_wdata   = dm_init_we ? init_data : rt_val;

  oc_wordmem #(
    .AW(DM_AW),
    .DW(XLEN)
  ) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (dm_idx),
    .rdata (dm_rdata)
  );

  // ---------------- write-back ----------------
  assign wb_dst = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_val = ctrl.wb_from_mem ? dm_rdata : alu_y;
  assign rf_we  = ctrl.reg_we & ~rst;

  // ---------------- next PC ----------------
  assign pc_plus4   = pc_q + PC_STEP;
  assign br_target  = pc_plus4 + (imm_sx << 2);
  assign jmp_target = {pc_plus4[XLEN-1:JT_W+2], cur_instr[JT_W-1:0], 2'b00};

  always_comb begin
    if (ctrl.is_jump) begin
      pc_next = jmp_target;
    end else if (ctrl.is_branch && alu_zero) begin
      pc_next = br_target;
    end else begin
      pc_next = pc_plus4;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_next;
    end
  end

  // ---------------- registered observation ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_wr_en   <= 1'b0;
      dbg_wr_addr <= '0;
      dbg_wr_data <= '0;
    end else begin
      dbg_wr_en   <= rf_we && (wb_dst != '0);
      dbg_wr_addr <= wb_dst;
      dbg_wr_data <= wb_val;
    end
  end

  assign dbg_pc = pc_q;

endmodule

// File: rtl/oc_checker.sv
module oc_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wr_en,
  input logic [4:0]  wr_addr
);

  logic [5:0]  opc;
  logic        is_store;
  logic        is_beq;
  logic        is_jump;
  logic        is_other;
  logic [31:0] seq_pc;
  logic [31:0] jump_dest;

  assign opc       = instr[31:26];
  assign is_store  = (opc == 6'd43);
  assign is_beq    = (opc == 6'd4);
  assign is_jump   = (opc == 6'd2);
  assign is_other  = !(opc == 6'd0 || opc == 6'd2 || opc == 6'd4 ||
                       opc == 6'd35 || opc == 6'd43);
  assign seq_pc    = pc + 32'd4;
  assign jump_dest = {seq_pc[31:28], instr[25:0], 2'b00};

  // R1: a reset edge leaves PC at zero and no write reported
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pc == 32'd0 && !wr_en));

  // R7: register zero is never reported as written
  a_r7_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != 5'd0));

  // R5: every PC value stays word aligned
  a_r5_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  // R5: a compare-and-branch never writes a register
  a_r5_branch_no_write: assert property (@(posedge clk) disable iff (rst)
    is_beq |=> !wr_en);

  // R4: a store never writes a register
  a_r4_store_no_write: assert property (@(posedge clk) disable iff (rst)
    is_store |=> !wr_en);

  // R6: a jump lands on the concatenated target and writes nothing
  a_r6_jump_dest: assert property (@(posedge clk) disable iff (rst)
    is_jump |=> (pc == $past(jump_dest) && !wr_en));

  // R8: an unlisted operation code only steps the PC
  a_r8_unknown_noop: assert property (@(posedge clk) disable iff (rst)
    is_other |=> (pc == $past(seq_pc) && !wr_en));

endmodule

bind onecyc_core oc_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (dbg_pc),
  .instr   (cur_instr),
  .wr_en   (dbg_wr_en),
  .wr_addr (dbg_wr_addr)
);

// File: tb/sim_onecyc_core.sv
`timescale 1ns/1ps
module sim_onecyc_core;

  localparam int IM_AW = 9;
  localparam int DM_AW = 6;
  localparam int IMW   = 1 << IM_AW;
  localparam int DMW   = 1 << DM_AW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             init_we = 1'b0;
  logic             init_sel = 1'b0;
  logic [IM_AW-1:0] init_addr = '0;
  logic [31:0]      init_data = '0;
  logic [31:0]      dbg_pc;
  logic             dbg_wr_en;
  logic [4:0]       dbg_wr_addr;
  logic [31:0]      dbg_wr_data;

  always #2.5 clk = ~clk;

  onecyc_core #(.IM_AW(IM_AW), .DM_AW(DM_AW)) u0 (
    .clk(clk), .rst(rst), .init_we(init_we), .init_sel(init_sel),
    .init_addr(init_addr), .init_data(init_data), .dbg_pc(dbg_pc),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [31:0] prog  [IMW];
  logic [31:0] dinit [DMW];
  logic [31:0] mreg  [32];
  logic [31:0] mdm   [DMW];
  logic [31:0] m_pc;
  int          plen = 0;

  logic [31:0] e_pc;
  logic        e_we;
  logic [4:0]  e_wa;
  logic [31:0] e_wd;
  string       e_tag;

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic emit(logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Instruction-level reference: one call per retired instruction
  task automatic model_step();
    logic [31:0] ins, a, b, sx, ad, res;
    logic [5:0]  op;
    logic [4:0]  dst;
    bit          wr;
    ins   = prog[m_pc[IM_AW+1:2]];
    op    = ins[31:26];
    a     = mreg[ins[25:21]];
    b     = mreg[ins[20:16]];
    sx    = {{16{ins[15]}}, ins[15:0]};
    ad    = a + sx;
    e_pc  = m_pc + 32'd4;
    wr    = 1'b0;
    dst   = 5'd0;
    res   = 32'd0;
    e_tag = "R8 unknown opcode";
    case (op)
      6'd0: begin
        e_tag = "R2 register-format R9";
        dst = ins[15:11];
        wr  = 1'b1;
        case (ins[5:0])
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd36: res = a & b;
          6'd37: res = a | b;
          default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
      end
      6'd35: begin
        e_tag = sx[31] ? "R3 load R10 negative offset" : "R3 load R4 R9";
        dst = ins[20:16];
        wr  = 1'b1;
        res = mdm[ad[DM_AW+1:2]];
      end
      6'd43: begin
        e_tag = sx[31] ? "R4 store R10 negative offset" : "R4 store";
        mdm[ad[DM_AW+1:2]] = b;
      end
      6'd4: begin
        e_tag = "R5 branch";
        if (a == b) e_pc = m_pc + 32'd4 + (sx << 2);
      end
      6'd2: begin
        e_tag = "R6 jump";
        e_pc = {e_pc[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    if (wr && dst == 5'd0) begin
      wr = 1'b0;
      e_tag = "R7 register zero";
    end
    if (wr) mreg[dst] = res;
    e_we = wr;
    e_wa = dst;
    e_wd = res;
    m_pc = e_pc;
  endtask

  task automatic init_write(bit sel, int idx, logic [31:0] w);
    @(negedge clk);
    init_we   = 1'b1;
    init_sel  = sel;
    init_addr = IM_AW'(idx);
    init_data = w;
  endtask

  initial begin
    automatic int fl[5] = '{32, 34, 36, 37, 42};
    automatic int k = 0;
    int h, halt_idx, hits;

    foreach (prog[i]) prog[i] = 32'd0;
    foreach (dinit[i]) dinit[i] = 32'd0;
    dinit[0] = 32'h0000_0000; dinit[1] = 32'h0000_0001;
    dinit[2] = 32'hFFFF_FFFF; dinit[3] = 32'h7FFF_FFFF;
    dinit[4] = 32'h8000_0000; dinit[5] = 32'h0000_0005;
    dinit[6] = 32'hFFFF_FFF9; dinit[7] = 32'h1234_5678;
    dinit[8] = 32'd64;        dinit[15] = 32'hCAFE_F00D;

    // load the eight operands into r1..r8, base 64 into r30 (R3)
    for (int i = 0; i < 8; i++) emit(enc_i(6'd35, 5'd0, 5'(i + 1), 16'(4 * i)));
    emit(enc_i(6'd35, 5'd0, 5'd30, 16'd32));
    // every ALU function over every operand pair (R2)
    for (int a = 1; a <= 8; a++)
      for (int b = 1; b <= 8; b++)
        for (int f = 0; f < 5; f++) begin
          emit(enc_r(5'(a), 5'(b), 5'(9 + (k % 20)), 6'(fl[f])));
          k++;
        end
    // stores then reloads, positive and negative offsets (R4, R10)
    emit(enc_i(6'd43, 5'd0, 5'd3, 16'd40));
    emit(enc_i(6'd43, 5'd30, 5'd6, 16'hFFF8));
    emit(enc_i(6'd35, 5'd0, 5'd29, 16'd40));
    emit(enc_i(6'd35, 5'd30, 5'd31, 16'hFFF8));
    emit(enc_i(6'd35, 5'd30, 5'd29, 16'hFFFC));
    // register zero target, then read it back (R7)
    emit(enc_r(5'd4, 5'd5, 5'd0, 6'd32));
    emit(enc_r(5'd0, 5'd0, 5'd9, 6'd37));
    // unlisted opcodes, then show r1 intact (R8)
    emit(32'h2001_0005);
    emit(32'hFC22_1234);
    emit(enc_r(5'd1, 5'd2, 5'd10, 6'd32));
    // branch not taken, then taken forward over two (R5)
    emit(enc_i(6'd4, 5'd1, 5'd2, 16'd5));
    emit(enc_i(6'd4, 5'd3, 5'd3, 16'd2));
    emit(enc_r(5'd2, 5'd2, 5'd12, 6'd32));
    emit(enc_r(5'd3, 5'd3, 5'd12, 6'd32));
    emit(enc_r(5'd5, 5'd5, 5'd13, 6'd32));
    // jump forward, backward branch, jump out, halt loop (R5, R6)
    h = plen;
    emit(enc_j(26'(h + 3)));
    emit(enc_r(5'd2, 5'd2, 5'd11, 6'd32));
    emit(enc_j(26'(h + 4)));
    emit(enc_i(6'd4, 5'd0, 5'd0, 16'hFFFD));
    halt_idx = plen;
    emit(enc_j(26'(halt_idx)));

    foreach (mreg[i]) mreg[i] = 32'd0;
    foreach (mdm[i]) mdm[i] = dinit[i];
    m_pc = 32'd0;

    for (int i = 0; i < IMW; i++) init_write(1'b0, i, prog[i]);
    for (int i = 0; i < DMW; i++) init_write(1'b1, i, dinit[i]);
    @(negedge clk);
    init_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(dbg_pc == 32'd0, "R1 reset pc", dbg_pc, 32'd0);
    check(dbg_wr_en == 1'b0, "R1 reset no write", 32'(dbg_wr_en), 32'd0);
    rst = 1'b0;

    hits = 0;
    for (int s = 0; s < 2000 && hits < 3; s++) begin
      model_step();
      @(negedge clk);
      check(dbg_pc == e_pc, {e_tag, " next pc"}, dbg_pc, e_pc);
      check(dbg_wr_en == e_we, {e_tag, " write flag"}, 32'(dbg_wr_en), 32'(e_we));
      if (e_we && dbg_wr_en) begin
        check(dbg_wr_addr == e_wa, {e_tag, " write reg"}, 32'(dbg_wr_addr), 32'(e_wa));
        check(dbg_wr_data == e_wd, {e_tag, " write value"}, dbg_wr_data, e_wd);
      end
      if (m_pc == 32'(4 * halt_idx)) hits++;
    end
    check(hits == 3, "R6 reached halt loop", 32'(hits), 32'd3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule